// File: doc/BRIEF.md
# Masked packed int64-to-float32 converter

This block is a vector execution unit. It converts up to eight signed 64-bit integer lanes into IEEE-754 single-precision values. The result vector is packed at half the width of the source. The number of active lanes follows a vector-length select. Each lane can be suppressed by its own write-mask bit. A suppressed lane either keeps the old destination lane or is cleared. A broadcast option feeds the lowest quadword of a memory-sourced operand to every lane.

An operation is presented with `in_valid`. Its result appears one clock later on registered outputs together with `out_valid`. If the reserved specifier field is not all ones, the operation is rejected: the block flags an invalid opcode and leaves the destination untouched. A sticky inexact flag collects precision loss from every lane that was actually converted.

Top module: `i64f32_vec_cvt`

## Requirements
- R1: `vlen_sel` selects the active lane count: 2'b00 gives 2 lanes, 2'b01 gives 4 lanes, and 2'b10 or 2'b11 gives 8 lanes. Every destination bit at or above 32 times the lane count is zero in the result.
- R2: Lane j converts `src[64j+63:64j]`, read as signed two's complement, into an IEEE single (sign bit 31, exponent bits 30:23 with bias 127, mantissa bits 22:0). The value is written to `dst[32j+31:32j]`.
- R3: `rmode` selects the rounding: 2'b00 nearest with ties to even, 2'b01 toward negative infinity, 2'b10 toward positive infinity, 2'b11 toward zero. A significand that carries out on rounding raises the exponent by one.
- R4: A zero lane gives 32'h00000000, and the value -2^63 gives 32'hDF000000 exactly.
- R5: With `mask_en` low, every active lane is converted whatever the `mask` bits hold.
- R6: With `mask_en` high, `mask[j]` low and `zero_mode` low, lane j of the result equals lane j of `old_dst`.
- R7: With `mask_en` high, `mask[j]` low and `zero_mode` high, lane j of the result is zero.
- R8: With both `bcast` and `mem_src` high, every active lane converts `src[63:0]`. `bcast` without `mem_src` has no effect.
- R9: If `spec_field` is not 4'b1111, then one cycle later `bad_op` is high, `dst` keeps its previous value and `inexact` is unchanged. For a legal operation `bad_op` is low.
- R10: `inexact` is set when any converted lane loses precision, and it clears only on reset. Masked-off lanes and inactive lanes never set it.
- R11: After reset all outputs are zero. `out_valid` is `in_valid` delayed by one clock. `dst`, `bad_op` and `inexact` change only in the clock after an accepted `in_valid`; `bad_op` is low after any cycle without `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| src | input | 512 | Eight packed signed 64-bit source lanes |
| vlen_sel | input | 2 | Vector length: 00 = 128, 01 = 256, else 512 bits |
| mask | input | 8 | Per-lane write mask |
| mask_en | input | 1 | Apply `mask` when high |
| zero_mode | input | 1 | Masked-off lanes: 1 = clear, 0 = keep old |
| bcast | input | 1 | Broadcast lowest quadword |
| mem_src | input | 1 | Source is a memory operand (enables broadcast) |
| old_dst | input | 256 | Previous destination value for merging |
| rmode | input | 2 | Rounding mode |
| spec_field | input | 4 | Reserved specifier, must be 4'b1111 |
| out_valid | output | 1 | Result registered this cycle |
| dst | output | 256 | Packed single-precision result |
| bad_op | output | 1 | Invalid opcode for the last operation |
| inexact | output | 1 | Sticky precision flag |

## Verification
Every result of this block (`out_valid`, `dst`, `bad_op` and the `inexact` update) is due at the first rising edge after the operation is presented. Nothing is due later. The bench drives each operation on a falling edge and lets one rising edge register it. It compares all outputs with its reference model on the next falling edge, so each comparison looks at exactly the cycle that operation owns. Idle cycles are compared the same way, which shows that the outputs hold.

// File: rtl/i64f32_pkg.sv
`timescale 1ns/1ps
package i64f32_pkg;

  typedef enum logic [1:0] {
    RM_NEAR  = 2'b00,
    RM_DOWN  = 2'b01,
    RM_UP    = 2'b10,
    RM_TRUNC = 2'b11
  } rnd_e;

  localparam int QW = 64;
  localparam int FW = 32;

  // position of the highest set bit (0 when v is zero)
  function automatic logic [5:0] top_one(input logic [63:0] v);
    logic [5:0] p;
    p = '0;
    for (int b = 0; b < 64; b++) begin
      if (v[b]) p = 6'(b);
    end
    return p;
  endfunction

  // returns {inexact, float32}
  function automatic logic [32:0] i64_to_f32(input logic [63:0] v, input rnd_e rm);
    logic        sgn;
    logic [63:0] mag;
    logic [63:0] nrm;
    logic [5:0]  p;
    logic [23:0] sig;
    logic        g, r, s, inx, up;
    logic [24:0] sum;
    logic [7:0]  ex;
    logic [22:0] man;
    sgn = v[63];
    mag = sgn ? (~v + 64'd1) : v;
    if (mag == 64'd0) return 33'd0;
    p   = top_one(mag);
    nrm = mag << (6'd63 - p);
    sig = nrm[63:40];
    g   = nrm[39];
    r   = nrm[38];
    s   = |nrm[37:0];
    inx = g | r | s;
    case (rm)
      RM_NEAR: up = g & (r | s | sig[0]);
      RM_DOWN: up = sgn & inx;
      RM_UP:   up = ~sgn & inx;
      default: up = 1'b0;
    endcase
    sum = {1'b0, sig} + {24'd0, up};
    ex  = 8'd127 + {2'b00, p} + {7'd0, sum[24]};
    man = sum[24] ? sum[23:1] : sum[22:0];
    return {inx, sgn, ex, man};
  endfunction

endpackage

// File: rtl/i64f32_lane.sv
`timescale 1ns/1ps
module i64f32_lane
  import i64f32_pkg::*;
(
  input  logic [63:0] qin,
  input  rnd_e        rm,
  output logic [31:0] fout,
  output logic        lost
);
  logic [32:0] packed_res;
  assign packed_res = i64_to_f32(qin, rm);
  assign fout = packed_res[31:0];
  assign lost = packed_res[32];
endmodule

// File: rtl/i64f32_lane_sel.sv
`timescale 1ns/1ps
module i64f32_lane_sel (
  input  logic        active,
  input  logic        mbit,
  input  logic        mask_en,
  input  logic        zero_mode,
  input  logic [31:0] cvt_f,
  input  logic        cvt_x,
  input  logic [31:0] old_f,
  output logic [31:0] res,
  output logic        take,
  output logic        res_x
);
  always_comb begin
    take  = active & (mbit | ~mask_en);
    res_x = take & cvt_x;
    if (!active)        res = '0;
    else if (take)      res = cvt_f;
    else if (zero_mode) res = '0;
    else                res = old_f;
  end
endmodule

// File: rtl/i64f32_vec_cvt.sv
`timescale 1ns/1ps
module i64f32_vec_cvt
  import i64f32_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [LANES*64-1:0] src,
  input  logic [1:0]          vlen_sel,
  input  logic [LANES-1:0]    mask,
  input  logic                mask_en,
  input  logic                zero_mode,
  input  logic                bcast,
  input  logic                mem_src,
  input  logic [LANES*32-1:0] old_dst,
  input  logic [1:0]          rmode,
  input  logic [3:0]          spec_field,
  output logic                out_valid,
  output logic [LANES*32-1:0] dst,
  output logic                bad_op,
  output logic                inexact
);
  localparam int LW = $clog2(LANES + 1);

  logic [LW-1:0]              nact;
  logic                       use_bc;
  logic                       legal;
  logic                       acc_go;
  logic                       any_inx;
  logic [LANES-1:0]           lane_take;
  logic [LANES-1:0]           lane_x;
  logic [LANES-1:0][FW-1:0]   lane_res;
  rnd_e                       rm;

  assign rm      = rnd_e'(rmode);
  assign use_bc  = bcast & mem_src;
  assign legal   = (spec_field == 4'b1111);
  assign acc_go  = in_valid & legal;
  assign any_inx = |lane_x;

  always_comb begin
    case (vlen_sel)
      2'b00:   nact = LW'(LANES / 4);
      2'b01:   nact = LW'(LANES / 2);
      default: nact = LW'(LANES);
    endcase
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [QW-1:0] lsrc;
    logic [FW-1:0] cf;
    logic          cx;
    assign lsrc = use_bc ? src[QW-1:0] : src[j*QW +: QW];
    i64f32_lane u_cvt (
      .qin (lsrc),
      .rm  (rm),
      .fout(cf),
      .lost(cx)
    );
    i64f32_lane_sel u_sel (
      .active   (LW'(j) < nact),
      .mbit     (mask[j]),
      .mask_en  (mask_en),
      .zero_mode(zero_mode),
      .cvt_f    (cf),
      .cvt_x    (cx),
      .old_f    (old_dst[j*FW +: FW]),
      .res      (lane_res[j]),
      .take     (lane_take[j]),
      .res_x    (lane_x[j])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      bad_op    <= 1'b0;
      inexact   <= 1'b0;
      dst       <= '0;
    end else begin
      out_valid <= in_valid;
      bad_op    <= in_valid & ~legal;
      if (acc_go) begin
        dst     <= lane_res;
        inexact <= inexact | any_inx;
      end
    end
  end
endmodule

// File: rtl/i64f32_vec_cvt_chk.sv
`timescale 1ns/1ps
module i64f32_vec_cvt_chk #(
  parameter int LANES = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [1:0]          vlen_sel,
  input logic [LANES-1:0]    mask,
  input logic                mask_en,
  input logic                zero_mode,
  input logic [LANES*32-1:0] old_dst,
  input logic [3:0]          spec_field,
  input logic                acc_go,
  input logic                any_inx,
  input logic                out_valid,
  input logic [LANES*32-1:0] dst,
  input logic                bad_op,
  input logic                inexact
);
  // R11
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !bad_op && $stable(dst) && $stable(inexact)));
  // R9
  reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && spec_field != 4'b1111) |=> (bad_op && $stable(dst) && $stable(inexact)));
  // R1
  short_vec_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_go && vlen_sel == 2'b00) |=> (dst[LANES*32-1:64] == '0));
  // R6
  merge_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_go && mask_en && !zero_mode && !mask[0]) |=> (dst[31:0] == $past(old_dst[31:0])));
  // R7
  zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_go && mask_en && zero_mode && !mask[0]) |=> (dst[31:0] == 32'd0));
  // R10
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inexact |=> inexact);
  // R10
  no_spurious_inx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inexact && !(acc_go && any_inx)) |=> !inexact);
endmodule

bind i64f32_vec_cvt i64f32_vec_cvt_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/i64f32_vec_cvt_test.sv
`timescale 1ns/1ps
module i64f32_vec_cvt_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [511:0] src = '0;
  logic [1:0]   vlen_sel = 2'b10;
  logic [7:0]   mask = '0;
  logic         mask_en = 1'b0;
  logic         zero_mode = 1'b0;
  logic         bcast = 1'b0;
  logic         mem_src = 1'b0;
  logic [255:0] old_dst = '0;
  logic [1:0]   rmode = 2'b00;
  logic [3:0]   spec_field = 4'hF;
  logic         out_valid;
  logic [255:0] dst;
  logic         bad_op;
  logic         inexact;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [255:0] m_dst = '0;
  logic         m_inx = 1'b0;
  logic         m_bad = 1'b0;
  logic         m_vld = 1'b0;

  always #2 clk = ~clk;

  i64f32_vec_cvt uut (.*);

  // reference: shift right until 24 bits, round on the remainder
  function automatic logic [31:0] ref_cvt(input logic [63:0] v, input int rm, output bit inx);
    bit          neg;
    logic [63:0] mag, q, rem, half, tmp;
    int          k, len, ex;
    bit          bump;
    logic [63:0] frac;
    neg = v[63];
    mag = neg ? (64'd0 - v) : v;
    inx = 1'b0;
    if (mag == 0) return 32'd0;
    q = mag; k = 0;
    while (q >= 64'd16777216) begin q = q >> 1; k++; end
    rem  = mag - (q << k);
    half = (k > 0) ? (64'd1 << (k - 1)) : 64'd0;
    inx  = (rem != 0);
    case (rm)
      0: bump = (rem > half) || (rem == half && rem != 0 && q[0]);
      1: bump = neg && inx;
      2: bump = !neg && inx;
      default: bump = 1'b0;
    endcase
    if (bump) q = q + 1;
    if (q == 64'd16777216) begin q = q >> 1; k++; end
    len = 0; tmp = q;
    while (tmp != 0) begin tmp = tmp >> 1; len++; end
    ex   = 127 + len - 1 + k;
    frac = (q << (24 - len)) & 64'h7FFFFF;
    return {neg, 8'(ex), frac[22:0]};
  endfunction

  task automatic check_bit(string tag, string what, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %b exp %b", tag, what, got, exp);
    end
  endtask

  task automatic check_vec(string tag, logic [255:0] got, logic [255:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s dst got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic compare(string tag);
    check_bit(tag, "out_valid", out_valid, m_vld);
    check_bit(tag, "bad_op", bad_op, m_bad);
    check_bit(tag, "inexact", inexact, m_inx);
    check_vec(tag, dst, m_dst);
  endtask

  // called at a falling edge; result checked at the next falling edge
  task automatic op(string tag, logic [511:0] s, logic [1:0] vl, logic [7:0] mk,
                    logic me, logic zm, logic bc, logic ms, logic [255:0] od,
                    logic [1:0] rm, logic [3:0] sp);
    int nl;
    logic [63:0] q;
    logic [255:0] nd;
    bit x, lx;
    in_valid = 1'b1; src = s; vlen_sel = vl; mask = mk; mask_en = me;
    zero_mode = zm; bcast = bc; mem_src = ms; old_dst = od; rmode = rm; spec_field = sp;
    nl = (vl == 2'b00) ? 2 : (vl == 2'b01) ? 4 : 8;
    nd = '0; x = 1'b0;
    for (int j = 0; j < nl; j++) begin
      q = (bc && ms) ? s[63:0] : s[j*64 +: 64];
      if (!me || mk[j]) begin
        nd[j*32 +: 32] = ref_cvt(q, int'(rm), lx);
        x = x | lx;
      end else if (!zm) begin
        nd[j*32 +: 32] = od[j*32 +: 32];
      end
    end
    m_vld = 1'b1;
    m_bad = (sp != 4'hF);
    if (sp == 4'hF) begin
      m_dst = nd;
      m_inx = m_inx | x;
    end
    @(negedge clk);
    in_valid = 1'b0;
    compare(tag);
  endtask

  task automatic idle(string tag);
    in_valid = 1'b0;
    src = {8{64'hFFFF_0000_1234_5679}};
    m_vld = 1'b0; m_bad = 1'b0;
    @(negedge clk);
    compare(tag);
  endtask

  function automatic logic [511:0] pack8(logic [63:0] a0, logic [63:0] a1, logic [63:0] a2,
      logic [63:0] a3, logic [63:0] a4, logic [63:0] a5, logic [63:0] a6, logic [63:0] a7);
    return {a7, a6, a5, a4, a3, a2, a1, a0};
  endfunction

  initial begin
    #(4 * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [511:0] s_exact, s_lossy, s_rnd;
    logic [255:0] oldp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R11 reset");

    // exact values incl. zero and -2^63
    s_exact = pack8(64'd1, -64'sd1, 64'd0, 64'h8000_0000_0000_0000,
                    64'd1024, -64'sd3, 64'd1 << 40, 64'd7);
    op("R2", s_exact, 2'b10, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, '0, 2'b00, 4'hF);
    checks++;
    if (dst[95:64] !== 32'h00000000 || dst[127:96] !== 32'hDF000000) begin
      errors++;
      $display("FAIL R4 lanes got %h %h exp 00000000 df000000", dst[95:64], dst[127:96]);
    end

    s_lossy = pack8(64'd16777217, 64'h7FFF_FFFF_FFFF_FFFF, 64'd123456789, -64'sd33554435,
                    64'd5, 64'd33554431, -64'sd16777219, 64'd99);
    // rejected operation leaves dst and inexact alone
    op("R9", s_lossy, 2'b10, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, '0, 2'b00, 4'b0111);
    idle("R9 clear");

    // masked-off lossy lanes must not set inexact; zeroing
    oldp = {8{32'hA5A5_5A5A}};
    op("R10 masked", s_lossy, 2'b10, 8'b0001_0000, 1'b1, 1'b1, 1'b0, 1'b0, oldp, 2'b00, 4'hF);
    op("R7", s_exact, 2'b10, 8'b0101_0101, 1'b1, 1'b1, 1'b0, 1'b0, oldp, 2'b00, 4'hF);
    op("R6", s_exact, 2'b10, 8'b1010_0101, 1'b1, 1'b0, 1'b0, 1'b0, oldp, 2'b00, 4'hF);

    // rounding modes on lossy values, incl. carry-out case 2^25-1
    s_rnd = s_lossy;
    for (int m = 0; m < 4; m++)
      op("R3", s_rnd, 2'b10, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, '0, 2'(m), 4'hF);
    op("R3 neg", pack8(-64'sd33554431, -64'sd5000000001, 64'd9007199254740993, -64'sd9007199254740995,
                        64'd6, 64'd17, -64'sd67108867, 64'd1), 2'b10, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, '0, 2'b01, 4'hF);

    // vector length
    op("R1 128", s_lossy, 2'b00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, {8{32'hFFFF_FFFF}}, 2'b00, 4'hF);
    op("R1 256", s_lossy, 2'b01, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b0, {8{32'hFFFF_FFFF}}, 2'b11, 4'hF);
    op("R1 11", s_exact, 2'b11, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, '0, 2'b00, 4'hF);

    // masking disabled ignores mask bits
    op("R5", s_exact, 2'b10, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, oldp, 2'b00, 4'hF);

    // broadcast
    op("R8 bcast", pack8(-64'sd12345, 64'd2, 64'd3, 64'd4, 64'd5, 64'd6, 64'd7, 64'd8),
       2'b10, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, '0, 2'b00, 4'hF);
    op("R8 no mem", pack8(-64'sd12345, 64'd2, 64'd3, 64'd4, 64'd5, 64'd6, 64'd7, 64'd8),
       2'b10, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, '0, 2'b00, 4'hF);
    op("R8 masked", pack8(64'd77, 64'd2, 64'd3, 64'd4, 64'd5, 64'd6, 64'd7, 64'd8),
       2'b01, 8'b0000_0110, 1'b1, 1'b0, 1'b1, 1'b1, oldp, 2'b00, 4'hF);

    // idle hold and sticky flag
    idle("R11 idle");
    idle("R10 sticky");
    op("R10 exact", s_exact, 2'b10, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, '0, 2'b00, 4'hF);
    op("R9 late", s_lossy, 2'b00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, '0, 2'b00, 4'b1110);
    idle("R11 end");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule